// File: doc/BRIEF.md
# Aggregating Edge Interrupt Controller

This block gathers 64 interrupt sources into one level interrupt line for a parent interrupt controller. Sources 0 to 20 come in as wired inputs and are caught on their rising edges. Sources 21 to 63 have no wire. A message-style write of the source number to a single doorbell register raises them. There is no matching clear doorbell, so every source has edge behaviour only.

Each source has a sticky cause bit and a mask bit. Both live in 32-bit registers reached over a simple single-cycle register port. Source n sits in register n/32 at bit n%32. Software clears a cause by writing a one to its bit, and disables a source by setting its mask bit. The output line is high while any cause bit is set and its mask bit is clear, delayed by one register stage.

Top module: `edge_irq_aggregator`

## Requirements
- R1: While reset is held, and on the first cycle after it, every cause bit reads 0, every mask bit reads 1 and `irq_out` is 0.
- R2: A 0-to-1 change on `wired_in[n]` (n from 0 to 20) sets cause bit n at the clock edge that samples the new level. The bit stays set while the input stays high. Once the bit is cleared, it does not set again until the input falls and rises again.
- R3: A write to offset 0x30 whose data bits [5:0] hold a value n from 21 to 63 sets cause bit n at that clock edge. Data bits [31:6] are ignored.
- R4: A doorbell write whose bits [5:0] name a source from 0 to 20 changes no cause bit.
- R5: The cause registers are at offset 0x00 (sources 0 to 31) and offset 0x04 (sources 32 to 63). A write there clears each bit whose data bit is 1 and leaves the bits written with 0 unchanged. A write of all ones clears the whole register.
- R6: When a set event (a wired edge or a doorbell) and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R7: The mask registers are at offset 0x20 (sources 0 to 31) and offset 0x24 (sources 32 to 63). A write replaces the register, a read returns it, and it changes at no other time. A mask bit of 1 disables its source and 0 enables it.
- R8: On each clock edge `irq_out` takes the OR over all 64 sources of (cause AND NOT mask), so it follows the register state one cycle later.
- R9: A read of any offset other than 0x00, 0x04, 0x20 and 0x24 returns 0, and a write to any offset other than those four and 0x30 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wired_in | input | 21 | Wired interrupt levels for sources 0 to 20, synchronous to clk |
| bus_wr | input | 1 | Register write strobe, one write per asserted cycle |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Merged interrupt line to the parent controller |

## Verification
The bench goes after these cases:
- A wired input held high after its cause was cleared. A level-sensitive capture would raise the cause again at once.
- A clear and a rising edge on the same bit in the same cycle. A clear-wins design would drop that edge.
- A doorbell that names a wired source, or carries junk in its upper data bits. A loose decoder would set a low cause bit, or alias the request onto another source.
- Mask changes that should move `irq_out` exactly one cycle later. This exposes an output that is combinational or delayed by two stages.
- A long random mix of edges, doorbells, partial clears, mask writes and writes to unused offsets, compared against a bench model. This reaches the decode and bit-position errors that the directed cases miss.

// File: rtl/irq_agg_pkg.sv
// Package: shared register offsets and address helper for the
// aggregating edge interrupt controller. Offsets are byte addresses.
package irq_agg_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] CAUSE_BASE   = 8'h00;
    localparam logic [ADDR_W-1:0] MASK_BASE    = 8'h20;
    localparam logic [ADDR_W-1:0] DOORBELL_OFS = 8'h30;

    // Byte address of the idx-th 32-bit register of a bank starting at base.
    function automatic logic [ADDR_W-1:0] reg_addr(input logic [ADDR_W-1:0] base,
                                                   input int idx);
        return base + ADDR_W'(4 * idx);
    endfunction
endpackage

// File: rtl/irq_edge_detect.sv
// Rising-edge detector for the wired sources.
// Assumes: inputs are already synchronous to clk. The history resets to 0,
// so an input that is high when reset is released counts as one edge.
module irq_edge_detect #(
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    output logic [WIDTH-1:0] rise_out
);
    logic [WIDTH-1:0] prev_q;

    // Remember the previous level of every input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_in;
    end

    // One-cycle pulse where the input is high now and was low before.
    always_comb rise_out = level_in & ~prev_q;
endmodule

// File: rtl/irq_doorbell_decode.sv
// Turns a write to the doorbell offset into a one-hot set request.
// Assumes: only the low SRC_W data bits are passed in; source numbers below
// NUM_WIRED belong to wired inputs and are dropped here.
module irq_doorbell_decode
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_WIRED = 21,
    localparam int SRC_W    = $clog2(NUM_SRC)
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  src_num,
    output logic [NUM_SRC-1:0] set_vec
);
    logic hit;

    // Accept only doorbell writes that name a message-raised source.
    always_comb hit = wr && (addr == DOORBELL_OFS) && (int'(src_num) >= NUM_WIRED);

    // Expand the source number into a one-hot set vector.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            set_vec[i] = hit && (int'(src_num) == i);
        end
    end
endmodule

// File: rtl/irq_src_bank.sv
// Cause and mask register bank with the register read mux.
// Causes are sticky and write-one-to-clear. A set in the same cycle beats a
// clear. Masks reset to all ones (disabled) and are written whole.
// Assumes: NUM_SRC is a multiple of REG_W.
module irq_src_bank
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int REG_W   = 32,
    localparam int NUM_REGS = NUM_SRC / REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [NUM_SRC-1:0] cause_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [REG_W-1:0]   rdata
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic             cause_sel;
        logic             mask_sel;
        logic [REG_W-1:0] cause_r;
        logic [REG_W-1:0] mask_r;
        logic [REG_W-1:0] set_slice;

        // Decode the two register hits of this slice.
        always_comb begin
            cause_sel = wr && (addr == reg_addr(CAUSE_BASE, g));
            mask_sel  = wr && (addr == reg_addr(MASK_BASE, g));
            set_slice = set_vec[g*REG_W +: REG_W];
        end

        // Sticky cause bits: clear-by-one, then OR in new sets so sets win.
        always_ff @(posedge clk) begin
            if (!rst_n)         cause_r <= '0;
            else if (cause_sel) cause_r <= (cause_r & ~wdata) | set_slice;
            else                cause_r <= cause_r | set_slice;
        end

        // Mask register: disabled at reset, replaced on write.
        always_ff @(posedge clk) begin
            if (!rst_n)        mask_r <= '1;
            else if (mask_sel) mask_r <= wdata;
        end

        assign cause_q[g*REG_W +: REG_W] = cause_r;
        assign mask_q[g*REG_W +: REG_W]  = mask_r;
    end

    // Read mux: unmapped offsets read as zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == reg_addr(CAUSE_BASE, i)) rdata = cause_q[i*REG_W +: REG_W];
            if (addr == reg_addr(MASK_BASE, i))  rdata = mask_q[i*REG_W +: REG_W];
        end
    end
endmodule

// File: rtl/irq_merge.sv
// Folds all enabled pending causes into one registered interrupt line.
// Assumes: mask bit 1 means disabled.
module irq_merge #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cause,
    input  logic [NUM_SRC-1:0] mask,
    output logic               irq_q
);
    logic [NUM_SRC-1:0] pending;

    // Enabled pending sources.
    always_comb pending = cause & ~mask;

    // Register the OR reduction so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pending;
    end
endmodule

// File: rtl/edge_irq_aggregator.sv
// Top level: the wired edge capture and the doorbell decode feed the set
// inputs of the cause/mask bank, whose enabled causes merge into irq_out.
// Assumes: one register access per cycle, reads are combinational.
module edge_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_WIRED = 21,
    parameter int REG_W     = 32,
    localparam int SRC_W    = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WIRED-1:0] wired_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic                 irq_out
);
    logic [NUM_WIRED-1:0] wired_rise;
    logic [NUM_SRC-1:0]   db_set;
    logic [NUM_SRC-1:0]   set_all;
    logic [NUM_SRC-1:0]   cause_q;
    logic [NUM_SRC-1:0]   mask_q;

    irq_edge_detect #(.WIDTH(NUM_WIRED)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (wired_in),
        .rise_out (wired_rise)
    );

    irq_doorbell_decode #(.NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED)) u_db (
        .wr      (bus_wr),
        .addr    (bus_addr),
        .src_num (bus_wdata[SRC_W-1:0]),
        .set_vec (db_set)
    );

    // Combine wired edges (low sources) with doorbell requests.
    always_comb begin
        set_all = db_set;
        set_all[NUM_WIRED-1:0] = set_all[NUM_WIRED-1:0] | wired_rise;
    end

    irq_src_bank #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_all),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cause_q (cause_q),
        .mask_q  (mask_q),
        .rdata   (bus_rdata)
    );

    irq_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .cause (cause_q),
        .mask  (mask_q),
        .irq_q (irq_out)
    );
endmodule

// File: rtl/irq_agg_checker.sv
// Property checker for edge_irq_aggregator, attached with bind.
// Observes the bus, the output and the bank's cause/mask state.
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_WIRED = 21,
    parameter int REG_W     = 32,
    localparam int NUM_REGS = NUM_SRC / REG_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [REG_W-1:0]   bus_wdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] cause_q,
    input logic [NUM_SRC-1:0] mask_q
);
    logic [NUM_SRC-1:0] clr_req;
    logic               mask_wr;

    // Bits a bus write asks to clear this cycle, and whether a mask is written.
    always_comb begin
        clr_req = '0;
        mask_wr = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (bus_wr && bus_addr == reg_addr(CAUSE_BASE, i))
                clr_req[i*REG_W +: REG_W] = bus_wdata;
            if (bus_wr && bus_addr == reg_addr(MASK_BASE, i))
                mask_wr = 1'b1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (cause_q == '0 && mask_q == '1 && !irq_out)); // R1

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (irq_out == |($past(cause_q) & ~$past(mask_q)))); // R8

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((($past(cause_q) & ~$past(clr_req)) & ~cause_q) == '0)); // R5

    AST_DB_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> $onehot0(cause_q[NUM_SRC-1:NUM_WIRED] & ~$past(cause_q[NUM_SRC-1:NUM_WIRED]))); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !mask_wr |=> $stable(mask_q)); // R7
endmodule

bind edge_irq_aggregator irq_agg_checker #(
    .NUM_SRC(NUM_SRC), .NUM_WIRED(NUM_WIRED), .REG_W(REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
);

// File: tb/sim_edge_irq_aggregator.sv
module sim_edge_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] wired_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;

    // Bench model of the register state.
    logic [63:0] m_cause;
    logic [63:0] m_mask;
    logic [20:0] m_prev;
    logic        m_irq;

    edge_irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .wired_in(wired_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_cause[31:0];
            8'h04:   return m_cause[63:32];
            8'h20:   return m_mask[31:0];
            8'h24:   return m_mask[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_val(input string tag, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Read one register at the current (negedge) time, no clock edge used.
    task automatic read_chk(input string tag, input logic [7:0] a);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        check_val(tag, $sformatf("read@%h", a), bus_rdata, exp_read(a));
    endtask

    task automatic read_all(input string tag);
        read_chk(tag, 8'h00);
        read_chk(tag, 8'h04);
        read_chk(tag, 8'h20);
        read_chk(tag, 8'h24);
    endtask

    // One clock: drive at negedge side, update the model at the edge, check irq.
    task automatic step(input logic [20:0] w, input logic wr,
                        input logic [7:0] a, input logic [31:0] d);
        logic [63:0] setv;
        logic [63:0] clr;
        logic        pend;
        wired_in = w;
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        pend = |(m_cause & ~m_mask);
        setv = '0;
        setv[20:0] = w & ~m_prev;
        m_prev = w;
        if (wr && a == 8'h30 && d[5:0] >= 6'd21) setv[d[5:0]] = 1'b1;
        clr = '0;
        if (wr && a == 8'h00) clr[31:0] = d;
        if (wr && a == 8'h04) clr[63:32] = d;
        m_cause = (m_cause & ~clr) | setv;
        if (wr && a == 8'h20) m_mask[31:0] = d;
        if (wr && a == 8'h24) m_mask[63:32] = d;
        m_irq = pend;
        @(negedge clk);
        bus_wr = 1'b0;
        check_val("R8", "irq_out", {31'd0, irq_out}, {31'd0, m_irq});
    endtask

    initial begin
        logic [31:0] seed;
        m_cause = '0;
        m_mask = '1;
        m_prev = '0;
        m_irq = 1'b0;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        read_all("R1");
        check_val("R1", "irq_out in reset", {31'd0, irq_out}, 32'd0);
        rst_n = 1'b1;
        step('0, 1'b0, 8'h00, 0);
        read_all("R1");

        // R7: enable everything
        step('0, 1'b1, 8'h20, 32'h0);
        step('0, 1'b1, 8'h24, 32'h0);
        read_all("R7");

        // R2: rising edge on wired 3, held high, cleared, must not re-set
        step(21'h8, 1'b0, 8'h00, 0);
        check_val("R2", "cause0 after edge", exp_read(8'h00), 32'h8);
        read_chk("R2", 8'h00);
        step(21'h8, 1'b0, 8'h00, 0);
        step(21'h8, 1'b1, 8'h00, 32'h8);
        step(21'h8, 1'b0, 8'h00, 0);
        step(21'h8, 1'b0, 8'h00, 0);
        read_chk("R2", 8'h00);
        check_val("R2", "held level no reset", exp_read(8'h00), 32'h0);

        // R3: doorbell source 40 with junk upper bits -> reg1 bit 8
        step(21'h8, 1'b1, 8'h30, 32'hABCD_00C0 | 32'd40);
        read_chk("R3", 8'h04);
        check_val("R3", "source 40 set", exp_read(8'h04), 32'h100);

        // R4: doorbell naming wired source 5 is ignored
        step(21'h8, 1'b1, 8'h30, 32'd5);
        read_chk("R4", 8'h00);
        check_val("R4", "no low set", exp_read(8'h00), 32'h0);

        // R6: rising edge on wired 7 together with full clear of reg0
        step(21'h8 | 21'h80, 1'b1, 8'h00, 32'hFFFF_FFFF);
        read_chk("R6", 8'h00);
        check_val("R6", "set beats clear", exp_read(8'h00), 32'h80);

        // R5: partial clear of reg1 leaves bits written with 0
        step(21'h88, 1'b1, 8'h30, 32'd63);
        step(21'h88, 1'b1, 8'h04, 32'h100);
        read_chk("R5", 8'h04);
        check_val("R5", "partial clear", exp_read(8'h04), 32'h8000_0000);

        // R9: unmapped offsets read zero and writes are dropped
        step(21'h88, 1'b1, 8'h10, 32'hFFFF_FFFF);
        step(21'h88, 1'b1, 8'h08, 32'hFFFF_FFFF);
        read_chk("R9", 8'h10);
        read_chk("R9", 8'h30);
        read_all("R9");

        // R8: masking everything drops irq_out one cycle later
        step(21'h88, 1'b1, 8'h20, 32'hFFFF_FFFF);
        step(21'h88, 1'b1, 8'h24, 32'hFFFF_FFFF);
        step(21'h88, 1'b0, 8'h00, 0);
        check_val("R8", "all masked", {31'd0, irq_out}, 32'd0);
        step(21'h88, 1'b1, 8'h24, 32'h7FFF_FFFF);
        step(21'h88, 1'b0, 8'h00, 0);
        check_val("R8", "unmask source 63", {31'd0, irq_out}, 32'd1);

        // Random mix against the model
        for (int n = 0; n < 4000; n++) begin
            logic [20:0] w;
            logic [31:0] r;
            w = m_prev ^ 21'($urandom & $urandom & $urandom);
            r = $urandom % 8;
            case (r)
                0, 1, 2: step(w, 1'b0, 8'h00, 0);
                3, 4:    step(w, 1'b1, 8'h30, $urandom);
                5:       step(w, 1'b1, ($urandom % 2) ? 8'h04 : 8'h00, $urandom & $urandom);
                6:       step(w, 1'b1, ($urandom % 2) ? 8'h24 : 8'h20, $urandom);
                default: step(w, 1'b1, 8'($urandom) | 8'h40, $urandom);
            endcase
            if (n % 16 == 15) read_all("R5");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule